// File: doc/BRIEF.md
# Per-Node Shared-Bus Ownership Arbiter

This block sits in each processor node of a shared-bus system with up to eight nodes. Every node owns one active-low request line, picked by its 3-bit node number. It also reads all eight lines, after the wired-AND, and two shared active-low priority lines: one for core-initiated accesses and one for high-priority DMA. No central arbiter exists. Each node keeps an identical copy of an ownership tracker that is fed only from the shared lines. All copies therefore agree on which node holds the bus, and only that node raises its bus-master output.

The local side gives a request level with a 2-bit kind code and a one-cycle done pulse that marks the end of a transaction. A node waits in a named state machine:
- `ST_IDLE` goes to `ST_WAIT` on a request (transition *accept*).
- `ST_WAIT` goes to `ST_OWN` when the tracker names this node the winner (*win*), or back to `ST_IDLE` when the request is withdrawn (*cancel*).
- `ST_OWN` goes to `ST_IDLE` on done (*release*), or to `ST_WAIT` when a higher-class claim appears on the priority lines (*preempt*).

A waiting node whose class is below the highest active priority line holds its request line inactive. As a result, only the top class competes.

Top module: `mpb_node`

## Requirements
- R1: A node drives low only the request output bit whose index equals its captured node number (000 selects bit 0, 111 selects bit 7). All other bits stay high. Lines are active-low, and an absent node's line reads high.
- R2: The node number is captured while rst_n is low. Changes to node_id_i after reset have no effect on which line the node drives.
- R3: Out of reset, bus_master_o is low and all request and priority outputs are high.
- R4: A request accepted at a clock edge drives the node's line low in the next cycle. If the bus is free, bus_master_o rises at the clock after that.
- R5: Among competing requests of the same class, the lowest-index active line wins. No two nodes are ever bus master in the same cycle.
- R6: A done pulse while owning drops bus_master_o and the request line at the next clock. A waiting node is granted in that release cycle, and its bus_master_o rises one clock later.
- R7: A pending core request (kind 10) drives the core priority line low while it waits. An owner doing normal or high-priority DMA that sees that line low drops bus_master_o at the next clock, and the core requester then gets the bus.
- R8: A pending high-priority DMA request (kind 01) drives the DMA priority line low. A normal-DMA owner yields at the next clock. A high-priority DMA owner keeps the bus against it.
- R9: A core owner keeps the bus until its done pulse, whatever the priority lines show.
- R10: A waiting node whose class is below the highest active priority line keeps its request line high.
- R11: A preempted owner keeps its request pending and wins the bus again after the higher-class work finishes.
- R12: Kind code 00 means normal DMA, and code 11 is treated the same as 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; node number is captured while low |
| node_id_i | input | 3 | Node number, only sampled during reset |
| req_valid_i | input | 1 | Local bus request, held until served or withdrawn |
| req_kind_i | input | 2 | Request class: 00/11 normal DMA, 01 high-priority DMA, 10 core |
| done_i | input | 1 | One-cycle pulse marking the end of the owner's transaction |
| req_lines_i | input | 8 | Sampled shared request lines, active-low |
| core_pri_n_i | input | 1 | Sampled shared core priority line, active-low |
| dma_pri_n_i | input | 1 | Sampled shared DMA priority line, active-low |
| req_n_o | output | 8 | This node's contribution to the request lines, active-low |
| core_pri_n_o | output | 1 | This node's contribution to the core priority line |
| dma_pri_n_o | output | 1 | This node's contribution to the DMA priority line |
| bus_master_o | output | 1 | High while this node owns the bus |

## Verification
The hardest case to reach is preemption in the middle of an ownership. A higher-class claim must appear while a lower-class node is partway through a long transaction, and the preempted node must stay pending and win again later. The bench drives eight nodes on shared wired-AND lines and holds each granted node's done pulse back for a set number of cycles. It waits until the long owner has the bus and then launches the core or high-DMA request a few cycles later. A scoreboard queue records the expected order of grants, including the return of the preempted node. Cycle-exact probes confirm the yield at the next clock and the handover in the release cycle.

// File: rtl/mpb_pkg.sv
package mpb_pkg;

    typedef enum logic [1:0] {
        K_NDMA     = 2'b00,
        K_HDMA     = 2'b01,
        K_CORE     = 2'b10,
        K_NDMA_ALT = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        CL_LOW = 2'd0,
        CL_MID = 2'd1,
        CL_TOP = 2'd2
    } pri_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_OWN  = 2'd2
    } node_st_e;

    function automatic pri_cls_e class_of(input logic [1:0] code);
        case (kind_e'(code))
            K_CORE:  return CL_TOP;
            K_HDMA:  return CL_MID;
            default: return CL_LOW;
        endcase
    endfunction

endpackage

// File: rtl/mpb_prio.sv
module mpb_prio
    import mpb_pkg::*;
(
    input  pri_cls_e cls_i,
    input  logic     core_act_i,
    input  logic     dma_act_i,
    output logic     outranked_o,
    output logic     core_claim_o,
    output logic     dma_claim_o
);

    // A class is outranked when a strictly higher class claims a priority line
    always_comb begin
        case (cls_i)
            CL_TOP:  outranked_o = 1'b0;
            CL_MID:  outranked_o = core_act_i;
            default: outranked_o = core_act_i | dma_act_i;
        endcase
    end

    assign core_claim_o = (cls_i == CL_TOP);
    assign dma_claim_o  = (cls_i == CL_MID);

endmodule

// File: rtl/mpb_track.sv
module mpb_track #(
    parameter int N_NODES = 8,
    parameter int ID_W    = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_NODES-1:0] req_act_i,
    output logic               grant_o,
    output logic [ID_W-1:0]    winner_o
);

    logic            owner_vld_q;
    logic [ID_W-1:0] owner_q;
    logic            bus_free;

    // Lowest active index wins
    always_comb begin
        winner_o = '0;
        for (int k = N_NODES - 1; k >= 0; k--) begin
            if (req_act_i[k]) begin
                winner_o = k[ID_W-1:0];
            end
        end
    end

    // Bus is free when no owner is recorded or the owner dropped its line
    assign bus_free = !owner_vld_q || !req_act_i[owner_q];
    assign grant_o  = bus_free && (|req_act_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_vld_q <= 1'b0;
            owner_q     <= '0;
        end else if (grant_o) begin
            owner_vld_q <= 1'b1;
            owner_q     <= winner_o;
        end else if (bus_free) begin
            owner_vld_q <= 1'b0;
        end
    end

endmodule

// File: rtl/mpb_node.sv
module mpb_node
    import mpb_pkg::*;
#(
    parameter int N_NODES = 8,
    parameter int ID_W    = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ID_W-1:0]    node_id_i,
    input  logic               req_valid_i,
    input  logic [1:0]         req_kind_i,
    input  logic               done_i,
    input  logic [N_NODES-1:0] req_lines_i,
    input  logic               core_pri_n_i,
    input  logic               dma_pri_n_i,
    output logic [N_NODES-1:0] req_n_o,
    output logic               core_pri_n_o,
    output logic               dma_pri_n_o,
    output logic               bus_master_o
);

    node_st_e           st_q, st_d;
    pri_cls_e           cls_q;
    logic [ID_W-1:0]    id_q;
    logic [N_NODES-1:0] own_mask;
    logic               outranked, core_claim, dma_claim;
    logic               grant;
    logic [ID_W-1:0]    winner;

    assign own_mask = {{(N_NODES-1){1'b0}}, 1'b1} << id_q;

    mpb_prio u_prio (
        .cls_i        (cls_q),
        .core_act_i   (!core_pri_n_i),
        .dma_act_i    (!dma_pri_n_i),
        .outranked_o  (outranked),
        .core_claim_o (core_claim),
        .dma_claim_o  (dma_claim)
    );

    mpb_track #(.N_NODES(N_NODES), .ID_W(ID_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_act_i (~req_lines_i),
        .grant_o   (grant),
        .winner_o  (winner)
    );

    // Node number is only loaded while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q <= node_id_i;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cls_q <= CL_LOW;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && req_valid_i) begin
                cls_q <= class_of(req_kind_i);
            end
        end
    end

    // Transitions: accept, cancel, win, release, preempt
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (req_valid_i) st_d = ST_WAIT;
            ST_WAIT: begin
                if (!req_valid_i)                                 st_d = ST_IDLE;
                else if (grant && winner == id_q && !outranked)   st_d = ST_OWN;
            end
            ST_OWN: begin
                if (done_i)         st_d = ST_IDLE;
                else if (outranked) st_d = ST_WAIT;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_n_o      = '1;
        core_pri_n_o = 1'b1;
        dma_pri_n_o  = 1'b1;
        bus_master_o = 1'b0;
        unique case (st_q)
            ST_WAIT: begin
                if (!outranked) req_n_o[id_q] = 1'b0;
                core_pri_n_o = !core_claim;
                dma_pri_n_o  = !dma_claim;
            end
            ST_OWN: begin
                req_n_o[id_q] = 1'b0;
                bus_master_o  = 1'b1;
            end
            default: ;
        endcase
    end

    AST_FOREIGN_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_n_o | own_mask) == '1)); // R1

    AST_ID_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(id_q)); // R2

    AST_GRANT_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_master_o) |-> $past(!req_n_o[id_q])); // R4

    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_master_o && done_i) |=> (!bus_master_o && req_n_o[id_q])); // R6

    AST_LOW_YIELDS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_master_o && cls_q == CL_LOW && !core_pri_n_i) |=> !bus_master_o); // R7

    AST_MID_YIELDS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_master_o && cls_q == CL_MID && !core_pri_n_i) |=> !bus_master_o); // R7

    AST_LOW_YIELDS_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_master_o && cls_q == CL_LOW && !dma_pri_n_i) |=> !bus_master_o); // R8

    AST_MID_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_master_o && cls_q == CL_MID && core_pri_n_i && !done_i) |=> bus_master_o); // R8

    AST_TOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_master_o && cls_q == CL_TOP && !done_i) |=> bus_master_o); // R9

    AST_WITHHOLD_OUTRANKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_master_o && !core_pri_n_i && cls_q != CL_TOP) |-> req_n_o[id_q]); // R10

endmodule

// File: tb/mpb_node_bench.sv
`timescale 1ns/1ps
module mpb_node_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ids    [8];
    logic [7:0] req_v  = '0;
    logic [1:0] kind_v [8];
    logic [7:0] done_v = '0;
    int         hold_v [8];
    int         cnt_v  [8];

    logic [7:0] req_n_all  [8];
    logic       core_n_all [8];
    logic       dma_n_all  [8];
    logic       bm_w       [8];
    logic [7:0] req_bus, bm;
    logic       core_bus, dma_bus;

    int errs = 0, checks = 0;
    int mon_errs = 0, mon_checks = 0, excl_bad = 0;
    int exp_q[$];

    always #4 clk = ~clk;

    always_comb begin
        req_bus  = '1;
        core_bus = 1'b1;
        dma_bus  = 1'b1;
        for (int i = 0; i < 8; i++) begin
            req_bus  = req_bus & req_n_all[i];
            core_bus = core_bus & core_n_all[i];
            dma_bus  = dma_bus & dma_n_all[i];
            bm[i]    = bm_w[i];
        end
    end

    for (genvar g = 0; g < 8; g++) begin : g_node
        mpb_node u_mpb_node (
            .clk          (clk),
            .rst_n        (rst_n),
            .node_id_i    (ids[g]),
            .req_valid_i  (req_v[g]),
            .req_kind_i   (kind_v[g]),
            .done_i       (done_v[g]),
            .req_lines_i  (req_bus),
            .core_pri_n_i (core_bus),
            .dma_pri_n_i  (dma_bus),
            .req_n_o      (req_n_all[g]),
            .core_pri_n_o (core_n_all[g]),
            .dma_pri_n_o  (dma_n_all[g]),
            .bus_master_o (bm_w[g])
        );
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // One cycle: step to the falling edge, then finish transactions of owners
    task automatic tick();
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            done_v[i] = 1'b0;
            if (bm[i]) begin
                if (hold_v[i] != 0) begin
                    cnt_v[i]++;
                    if (cnt_v[i] >= hold_v[i]) begin
                        done_v[i] = 1'b1;
                        req_v[i]  = 1'b0;
                        cnt_v[i]  = 0;
                    end
                end
            end else begin
                cnt_v[i] = 0;
            end
        end
    endtask

    task automatic post(input int n, input logic [1:0] kind, input int hold);
        req_v[n]  = 1'b1;
        kind_v[n] = kind;
        hold_v[n] = hold;
    endtask

    task automatic expect_grant(input int n);
        exp_q.push_back(n);
    endtask

    task automatic wait_owner(input int n);
        for (int k = 0; k < 60 && !bm[n]; k++) tick();
    endtask

    task automatic wait_done(input int n);
        for (int k = 0; k < 60 && !done_v[n]; k++) tick();
    endtask

    task automatic wait_quiet(input string rq);
        for (int k = 0; k < 2000; k++) begin
            if (bm == 8'h00 && req_v == 8'h00) break;
            tick();
        end
        tick();
        chk(exp_q.size() == 0, rq, "grant order drained", exp_q.size(), 0);
    endtask

    // Monitor: pop the expected owner on every rising bus-master bit
    initial begin
        logic [7:0] prev;
        prev = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if ($countones(bm) > 1) excl_bad++;
                for (int i = 0; i < 8; i++) begin
                    if (bm[i] && !prev[i]) begin
                        mon_checks++;
                        if (exp_q.size() == 0) begin
                            mon_errs++;
                            $display("FAIL R5 unexpected grant: actual=%0d expected=none", i);
                        end else begin
                            int e;
                            e = exp_q.pop_front();
                            if (e != i) begin
                                mon_errs++;
                                $display("FAIL R5 grant order: actual=%0d expected=%0d", i, e);
                            end
                        end
                    end
                end
            end
            prev = bm;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL R4 watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs + mon_errs + 1, checks + mon_checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            ids[i]    = 3'(i);
            kind_v[i] = 2'b00;
            hold_v[i] = 0;
            cnt_v[i]  = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R3: quiet after reset
        chk(bm == 8'h00, "R3", "bus master after reset", bm, 0);
        chk(req_bus == 8'hFF, "R3", "request lines after reset", req_bus, 8'hFF);
        chk({core_bus, dma_bus} == 2'b11, "R3", "priority lines after reset", {core_bus, dma_bus}, 3);

        // R2: node number changes after reset are ignored
        ids[3] = 3'd0;
        ids[6] = 3'd1;
        post(3, 2'b00, 2);
        expect_grant(3);
        tick();
        chk(req_bus == 8'hF7, "R2", "line after id change", req_bus, 8'hF7);
        wait_quiet("R2");

        // R1, R4, R6: single request timing
        post(5, 2'b00, 3);
        expect_grant(5);
        tick();
        chk(req_bus == 8'hDF, "R1", "own line only", req_bus, 8'hDF);
        chk(bm == 8'h00, "R4", "no grant yet", bm, 0);
        tick();
        chk(bm == 8'h20, "R4", "grant one clock after line", bm, 8'h20);
        wait_done(5);
        tick();
        chk(bm == 8'h00 && req_bus == 8'hFF, "R6", "release after done", {bm, req_bus}, 16'h00FF);
        wait_quiet("R6");

        // R5, R6: simultaneous normal requests, lowest index first
        post(6, 2'b00, 3);
        post(2, 2'b00, 3);
        post(4, 2'b00, 3);
        expect_grant(2); expect_grant(4); expect_grant(6);
        tick();
        chk(req_bus == 8'hAB, "R5", "three lines active", req_bus, 8'hAB);
        tick();
        chk(bm == 8'h04, "R5", "lowest wins", bm, 8'h04);
        wait_done(2);
        tick();
        chk(bm == 8'h00, "R6", "gap after release", bm, 0);
        tick();
        chk(bm == 8'h10, "R6", "handover in release cycle", bm, 8'h10);
        wait_quiet("R5");

        // R7, R11: core preempts normal DMA owner, which later regains
        post(1, 2'b00, 30);
        expect_grant(1);
        wait_owner(1);
        repeat (3) tick();
        post(6, 2'b10, 5);
        expect_grant(6); expect_grant(1);
        tick();
        chk(core_bus == 1'b0, "R7", "core priority driven", core_bus, 0);
        tick();
        chk(bm == 8'h00, "R7", "normal owner yields", bm, 0);
        tick();
        chk(bm == 8'h40, "R7", "core requester owns", bm, 8'h40);
        wait_quiet("R11");

        // R8: high DMA preempts normal DMA owner
        post(0, 2'b00, 30);
        expect_grant(0);
        wait_owner(0);
        repeat (2) tick();
        post(7, 2'b01, 4);
        expect_grant(7); expect_grant(0);
        tick();
        chk(dma_bus == 1'b0, "R8", "dma priority driven", dma_bus, 0);
        tick();
        chk(bm == 8'h00, "R8", "normal owner yields to high dma", bm, 0);
        tick();
        chk(bm == 8'h80, "R8", "high dma requester owns", bm, 8'h80);
        wait_quiet("R11");

        // R8: high DMA owner keeps bus against another high DMA request
        post(3, 2'b01, 12);
        expect_grant(3);
        wait_owner(3);
        tick();
        post(2, 2'b01, 3);
        expect_grant(2);
        repeat (3) tick();
        chk(bm == 8'h08, "R8", "high dma owner keeps bus", bm, 8'h08);
        wait_quiet("R8");

        // R7: core preempts high DMA owner
        post(2, 2'b01, 30);
        expect_grant(2);
        wait_owner(2);
        tick();
        post(5, 2'b10, 3);
        expect_grant(5); expect_grant(2);
        tick();
        tick();
        chk(bm == 8'h00, "R7", "high dma owner yields to core", bm, 0);
        tick();
        chk(bm == 8'h20, "R7", "core requester owns", bm, 8'h20);
        wait_quiet("R11");

        // R9: core owner keeps bus against core and high DMA waiters
        post(5, 2'b10, 10);
        expect_grant(5);
        wait_owner(5);
        tick();
        post(0, 2'b10, 3);
        post(1, 2'b01, 3);
        expect_grant(0); expect_grant(1);
        repeat (3) tick();
        chk(bm == 8'h20, "R9", "core owner keeps bus", bm, 8'h20);
        wait_quiet("R9");

        // R10, R12: only the top class competes; code 11 ranks as normal DMA
        post(0, 2'b11, 3);
        post(4, 2'b01, 3);
        post(6, 2'b10, 3);
        expect_grant(6); expect_grant(4); expect_grant(0);
        tick();
        chk(req_bus == 8'hBF, "R10", "lower classes withhold lines", req_bus, 8'hBF);
        tick();
        chk(bm == 8'h40, "R10", "core class wins", bm, 8'h40);
        wait_quiet("R12");

        chk(excl_bad == 0, "R5", "cycles with two masters", excl_bad, 0);

        $display("Result: errors=%0d of %0d checks", errs + mon_errs, checks + mon_checks);
        $finish;
    end

endmodule